// File: doc/BRIEF.md
# Tamper-Erased Backup Register File

A bank of 32-bit general-purpose backup registers that lives in an always-powered domain and sits on a simple single-cycle register bus. Software stores state in these registers that must survive a system reset. Only the backup-domain reset sets them to zero.

Three tamper inputs each set a sticky flag. Software reads the flags from a status register and clears them one at a time through a write-1-to-clear register. A tamper pulse wipes every backup register. While any flag stays set, the registers are held at zero, so writes made during that time are lost. A pulse that signals that readout protection is being disabled also wipes the registers, and it leaves the flags as they are.

The bus has one-cycle read latency. The address presented with `sel_i` high and `we_i` low returns its data on `rdata_o` after the next rising clock edge. A write takes effect on that same edge.

Top module: `tamp_bkp_regs`

## Requirements
- R1: Five 32-bit backup registers sit at byte offsets 0x100 + 4*k, for k from 0 to 4. A word written to one of them is returned by a later read of that offset, one cycle after the read is presented.
- R2: While `bkp_rst_ni` is low, every backup register and every tamper flag is zero.
- R3: A low level on `rst_ni` changes neither the backup registers nor the flags. It forces `rdata_o` to zero while asserted.
- R4: A one-cycle high on `tamper_i[n]` sets flag n, which appears on `flags_o[n]` and in bit n of the status register at offset 0x030 from the next cycle. The flag stays set until software clears it. No flag rises without a pulse.
- R5: A tamper pulse sets every backup register to zero at the same clock edge that sets the flag.
- R6: While any flag is set, writes to the backup registers do not persist and reads of them return zero. Once all flags are clear, writes work again.
- R7: A one-cycle high on `rdp_off_i` sets every backup register to zero and leaves the flags unchanged.
- R8: Writing the clear register at offset 0x03C with bit n = 1 (n from 0 to 2) clears flag n. Bits written as 0 leave their flag unchanged, and bits 31:3 are ignored.
- R9: If a tamper pulse and a clear for the same flag occur in the same cycle, the flag ends up set.
- R10: The status register cannot be written. The clear register reads as zero. Any other offset that does not match a backup register, including offsets that are not word-aligned, reads as zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | System reset, active low, asynchronous; clears only the read data |
| bkp_rst_ni | input | 1 | Backup-domain reset, active low, asynchronous |
| sel_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 9 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the read |
| tamper_i | input | 3 | Tamper event pulses, one per flag |
| rdp_off_i | input | 1 | Readout-protection-disable pulse |
| flags_o | output | 3 | Current tamper flags |

## Verification
Directed sequences exercise each wipe source on its own: a single tamper bit, several tamper bits together, the protection-disable pulse, and the backup-domain reset. After each one the bench reads the registers back, which shows which event cleared them and whether the flags were touched. Clear writes use all-zero, reserved-only and single-bit data, and one is issued in the same cycle as a tamper pulse on the same flag, so that write-1-to-clear decoding can be told apart from set/clear priority. A seeded random mix of backup writes, reads, stray-offset accesses, tamper pulses and clears is then checked against a bench model. This shows whether writes made while a flag is set are dropped and whether they take effect again once the last flag is cleared.

// File: rtl/tamp_bkp_pkg.sv
package tamp_bkp_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 9;
  localparam int unsigned BKP_BASE   = 32'h100;
  localparam int unsigned BKP_STRIDE = 4;
  localparam int unsigned STAT_OFS   = 32'h030;
  localparam int unsigned CLR_OFS    = 32'h03C;
endpackage

// File: rtl/tamp_bkp_decode.sv
module tamp_bkp_decode
  import tamp_bkp_pkg::*;
#(
  parameter int unsigned NUM_BKP = 5
) (
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_BKP-1:0] bkp_hit_o,
  output logic               stat_hit_o,
  output logic               clr_hit_o
);
  for (genvar k = 0; k < NUM_BKP; k++) begin : g_hit
    localparam logic [ADDR_W-1:0] OFS = ADDR_W'(BKP_BASE + BKP_STRIDE * k);
    assign bkp_hit_o[k] = (addr_i == OFS);
  end

  assign stat_hit_o = (addr_i == ADDR_W'(STAT_OFS));
  assign clr_hit_o  = (addr_i == ADDR_W'(CLR_OFS));
endmodule

// File: rtl/tamp_flag_bank.sv
module tamp_flag_bank #(
  parameter int unsigned NUM_TAMP = 3
) (
  input  logic                clk_i,
  input  logic                bkp_rst_ni,
  input  logic [NUM_TAMP-1:0] set_i,
  input  logic [NUM_TAMP-1:0] clr_i,
  output logic [NUM_TAMP-1:0] flags_o
);
  logic [NUM_TAMP-1:0] flags_q;

  // set has priority over a same-cycle clear
  always_ff @(posedge clk_i or negedge bkp_rst_ni) begin
    if (!bkp_rst_ni) flags_q <= '0;
    else             flags_q <= (flags_q & ~clr_i) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/bkp_reg_bank.sv
module bkp_reg_bank #(
  parameter int unsigned NUM_BKP = 5,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                            clk_i,
  input  logic                            bkp_rst_ni,
  input  logic                            wipe_i,
  input  logic [NUM_BKP-1:0]              wr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  output logic [NUM_BKP-1:0][DATA_W-1:0]  regs_o
);
  for (genvar k = 0; k < NUM_BKP; k++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge bkp_rst_ni) begin
      if (!bkp_rst_ni)  q <= '0;
      else if (wipe_i)  q <= '0;
      else if (wr_i[k]) q <= wdata_i;
    end
    assign regs_o[k] = q;
  end
endmodule

// File: rtl/tamp_bkp_regs.sv
module tamp_bkp_regs
  import tamp_bkp_pkg::*;
#(
  parameter int unsigned NUM_BKP  = 5,
  parameter int unsigned NUM_TAMP = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bkp_rst_ni,
  input  logic                sel_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  input  logic [NUM_TAMP-1:0] tamper_i,
  input  logic                rdp_off_i,
  output logic [NUM_TAMP-1:0] flags_o
);
  logic                           wr_en, rd_en, wipe;
  logic [NUM_BKP-1:0]             bkp_hit, bkp_wr;
  logic                           stat_hit, clr_hit;
  logic [NUM_TAMP-1:0]            flags, clr_vec;
  logic [NUM_BKP-1:0][DATA_W-1:0] bkp_q;
  logic [DATA_W-1:0]              rd_mux, rdata_q;

  assign wr_en = sel_i & we_i;
  assign rd_en = sel_i & ~we_i;

  tamp_bkp_decode #(.NUM_BKP(NUM_BKP)) u_dec (
    .addr_i     (addr_i),
    .bkp_hit_o  (bkp_hit),
    .stat_hit_o (stat_hit),
    .clr_hit_o  (clr_hit)
  );

  assign clr_vec = (wr_en && clr_hit) ? wdata_i[NUM_TAMP-1:0] : '0;

  tamp_flag_bank #(.NUM_TAMP(NUM_TAMP)) u_flags (
    .clk_i      (clk_i),
    .bkp_rst_ni (bkp_rst_ni),
    .set_i      (tamper_i),
    .clr_i      (clr_vec),
    .flags_o    (flags)
  );

  // a new event wipes at once; a pending flag keeps the bank at zero
  assign wipe   = (|tamper_i) | (|flags) | rdp_off_i;
  assign bkp_wr = wr_en ? bkp_hit : '0;

  bkp_reg_bank #(.NUM_BKP(NUM_BKP), .DATA_W(DATA_W)) u_bank (
    .clk_i      (clk_i),
    .bkp_rst_ni (bkp_rst_ni),
    .wipe_i     (wipe),
    .wr_i       (bkp_wr),
    .wdata_i    (wdata_i),
    .regs_o     (bkp_q)
  );

  always_comb begin
    rd_mux = '0;
    if (stat_hit) rd_mux = DATA_W'(flags);
    for (int k = 0; k < NUM_BKP; k++) begin
      if (bkp_hit[k]) rd_mux = rd_mux | bkp_q[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
  assign flags_o = flags;
endmodule

// File: rtl/tamp_bkp_regs_chk.sv
module tamp_bkp_regs_chk
  import tamp_bkp_pkg::*;
#(
  parameter int unsigned NUM_BKP  = 5,
  parameter int unsigned NUM_TAMP = 3
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           bkp_rst_ni,
  input logic                           sel_i,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic [DATA_W-1:0]              rdata_o,
  input logic [NUM_TAMP-1:0]            tamper_i,
  input logic                           rdp_off_i,
  input logic [NUM_TAMP-1:0]            flags_o,
  input logic [NUM_BKP-1:0][DATA_W-1:0] bkp_q
);
  logic bkp_map, clr_wr;

  always_comb begin
    bkp_map = (addr_i >= ADDR_W'(BKP_BASE)) &&
              (addr_i < ADDR_W'(BKP_BASE + BKP_STRIDE * NUM_BKP)) &&
              (addr_i[1:0] == 2'b00);
    clr_wr  = sel_i && we_i && (addr_i == ADDR_W'(CLR_OFS));
  end

  AST_TAMPER_WIPE: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (|tamper_i) |=> (bkp_q == '0)); // R5

  AST_FLAG_HOLDS_ZERO: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (|flags_o) |=> (bkp_q == '0)); // R6

  AST_RDP_WIPE: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    rdp_off_i |=> (bkp_q == '0)); // R7

  AST_RDP_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (rdp_off_i && tamper_i == '0 && !clr_wr) |=> (flags_o == $past(flags_o))); // R7

  AST_NO_SPURIOUS_FLAG: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (tamper_i == '0) |=> ((flags_o & ~$past(flags_o)) == '0)); // R4

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (|tamper_i) |=> ((flags_o & $past(tamper_i)) == $past(tamper_i))); // R9

  AST_CLEAR_W1C: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (clr_wr && tamper_i == '0) |=> ((flags_o & $past(wdata_i[NUM_TAMP-1:0])) == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!bkp_rst_ni || !rst_ni)
    (sel_i && !we_i && !bkp_map && addr_i != ADDR_W'(STAT_OFS)) |=> (rdata_o == '0)); // R10
endmodule

bind tamp_bkp_regs tamp_bkp_regs_chk #(.NUM_BKP(NUM_BKP), .NUM_TAMP(NUM_TAMP)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bkp_rst_ni (bkp_rst_ni),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .tamper_i   (tamper_i),
  .rdp_off_i  (rdp_off_i),
  .flags_o    (flags_o),
  .bkp_q      (bkp_q)
);

// File: tb/tamp_bkp_regs_test.sv
module tamp_bkp_regs_test;
  logic        clk_i = 1'b0;
  logic        rst_ni, bkp_rst_ni, sel_i, we_i, rdp_off_i;
  logic [8:0]  addr_i;
  logic [31:0] wdata_i, rdata_o;
  logic [2:0]  tamper_i, flags_o;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_bkp [5];
  logic [2:0]  m_flg;

  localparam logic [8:0] STAT = 9'h030;
  localparam logic [8:0] CLR  = 9'h03C;

  always #10 clk_i = ~clk_i;

  tamp_bkp_regs uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bkp_rst_ni(bkp_rst_ni),
    .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .tamper_i(tamper_i), .rdp_off_i(rdp_off_i),
    .flags_o(flags_o)
  );

  function automatic logic [8:0] bkp_addr(input int k);
    return 9'(32'h100 + 4 * k);
  endfunction

  function automatic bit is_bkp(input logic [8:0] a);
    return (a >= 9'h100) && (a < 9'h114) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [31:0] model_read(input logic [8:0] a);
    if (a == STAT) return {29'b0, m_flg};
    if (is_bkp(a)) return m_bkp[(a - 9'h100) >> 2];
    return 32'h0;
  endfunction

  task automatic model_step(input bit s, input bit w, input logic [8:0] a,
                            input logic [31:0] d, input logic [2:0] t, input bit r);
    bit         wipe;
    logic [2:0] clr;
    clr  = (s && w && a == CLR) ? d[2:0] : 3'b0;
    wipe = (t != 0) || (m_flg != 0) || r;
    m_flg = (m_flg & ~clr) | t;
    if (wipe) begin
      for (int k = 0; k < 5; k++) m_bkp[k] = 32'h0;
    end else if (s && w && is_bkp(a)) begin
      m_bkp[(a - 9'h100) >> 2] = d;
    end
  endtask

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, pass one posedge, check at the following negedge
  task automatic op(input bit s, input bit w, input logic [8:0] a, input logic [31:0] d,
                    input logic [2:0] t, input bit r, input string req);
    logic [31:0] exp;
    sel_i = s; we_i = w; addr_i = a; wdata_i = d; tamper_i = t; rdp_off_i = r;
    exp = model_read(a);
    model_step(s, w, a, d, t, r);
    @(negedge clk_i);
    sel_i = 1'b0; we_i = 1'b0; tamper_i = 3'b0; rdp_off_i = 1'b0;
    if (s && !w) check(rdata_o, exp, req);
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input string req);
    op(1'b1, 1'b1, a, d, 3'b0, 1'b0, req);
  endtask

  task automatic rd(input logic [8:0] a, input string req);
    op(1'b1, 1'b0, a, 32'h0, 3'b0, 1'b0, req);
  endtask

  task automatic pulse(input logic [2:0] t, input bit r, input string req);
    op(1'b0, 1'b0, 9'h0, 32'h0, t, r, req);
  endtask

  task automatic chk_flags(input string req);
    check({29'b0, flags_o}, {29'b0, m_flg}, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_ni = 1'b0; bkp_rst_ni = 1'b0;
    sel_i = 1'b0; we_i = 1'b0; addr_i = '0; wdata_i = '0; tamper_i = '0; rdp_off_i = 1'b0;
    m_flg = 3'b0;
    for (int k = 0; k < 5; k++) m_bkp[k] = 32'h0;
    repeat (3) @(negedge clk_i);
    check(rdata_o, 32'h0, "R3");
    chk_flags("R2");
    rst_ni = 1'b1; bkp_rst_ni = 1'b1;
    @(negedge clk_i);

    // R2: reset values
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R2");

    // R1: write / read each register
    for (int k = 0; k < 5; k++) wr(bkp_addr(k), 32'hA5000000 | 32'(k * 32'h1111), "R1");
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R1");

    // R3: system reset keeps contents
    rd(bkp_addr(2), "R1");
    rst_ni = 1'b0;
    #1 check(rdata_o, 32'h0, "R3");
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_flags("R3");
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R3");

    // R10: status read-only, clear reads zero, stray offsets
    wr(STAT, 32'hFFFF_FFFF, "R10");
    rd(STAT, "R10");
    rd(CLR, "R10");
    wr(9'h101, 32'hDEAD_BEEF, "R10");
    rd(9'h101, "R10");
    rd(9'h114, "R10");
    rd(9'h000, "R10");
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R10");

    // R4 / R5: single tamper
    pulse(3'b010, 1'b0, "R5");
    chk_flags("R4");
    rd(STAT, "R4");
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R5");
    // R6: writes during set flag lost
    wr(bkp_addr(1), 32'h1234_5678, "R6");
    rd(bkp_addr(1), "R6");
    // R8: zero and reserved bits
    wr(CLR, 32'h0, "R8");
    chk_flags("R8");
    wr(CLR, 32'hFFFF_FFF8, "R8");
    chk_flags("R8");
    wr(CLR, 32'h0000_0002, "R8");
    chk_flags("R8");
    wr(bkp_addr(1), 32'h1234_5678, "R6");
    rd(bkp_addr(1), "R6");

    // R9: set vs clear same cycle
    op(1'b1, 1'b1, CLR, 32'h1, 3'b001, 1'b0, "R9");
    chk_flags("R9");
    rd(STAT, "R9");
    wr(CLR, 32'h1, "R8");
    chk_flags("R8");

    // multi-flag: partial clear keeps bank blocked
    pulse(3'b101, 1'b0, "R4");
    chk_flags("R4");
    wr(CLR, 32'h1, "R8");
    chk_flags("R8");
    wr(bkp_addr(3), 32'hCAFE_0003, "R6");
    rd(bkp_addr(3), "R6");
    wr(CLR, 32'h4, "R8");
    wr(bkp_addr(3), 32'hCAFE_0003, "R6");
    rd(bkp_addr(3), "R6");

    // R7: protection-disable wipe, flags kept
    for (int k = 0; k < 5; k++) wr(bkp_addr(k), 32'h7700_0000 + 32'(k), "R1");
    pulse(3'b000, 1'b1, "R7");
    chk_flags("R7");
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R7");
    pulse(3'b100, 1'b0, "R4");
    pulse(3'b000, 1'b1, "R7");
    chk_flags("R7");
    wr(CLR, 32'h7, "R8");

    // R2: backup reset mid-run
    wr(bkp_addr(4), 32'h0BAD_F00D, "R1");
    pulse(3'b010, 1'b0, "R4");
    wr(bkp_addr(0), 32'h1, "R6");
    bkp_rst_ni = 1'b0;
    m_flg = 3'b0;
    for (int k = 0; k < 5; k++) m_bkp[k] = 32'h0;
    @(negedge clk_i);
    chk_flags("R2");
    bkp_rst_ni = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 5; k++) rd(bkp_addr(k), "R2");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      logic [8:0]  a;
      logic [31:0] d;
      sel = $urandom_range(0, 99);
      a   = bkp_addr(int'($urandom_range(0, 4)));
      d   = $urandom;
      if (sel < 40)      wr(a, d, (m_flg != 0) ? "R6" : "R1");
      else if (sel < 72) rd(a, (m_flg != 0) ? "R6" : "R1");
      else if (sel < 78) rd(STAT, "R4");
      else if (sel < 86) wr(CLR, d, "R8");
      else if (sel < 89) pulse(3'($urandom_range(1, 7)), 1'b0, "R5");
      else if (sel < 91) pulse(3'b000, 1'b1, "R7");
      else if (sel < 95) rd(9'($urandom_range(0, 511)), "R10");
      else               wr(9'($urandom_range(0, 511)), d, "R10");
      chk_flags("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule